// File: doc/BRIEF.md
# Register access violation monitor

This block sits beside the register decoder of a peripheral and watches every access on a simple register bus that carries an address, a read strobe and a write strobe. For each access it looks up the attribute of the addressed word (read-write, read-only, write-only, undefined, and whether the word is guarded by write protection). It then decides whether the write may reach the register file, and records any misuse in one read-only status word.

The status word holds three sticky flags: one for a blocked write to a guarded word, one for a software access error, and one for an internal sequencer fault reported on a dedicated pulse input. It also holds a two-bit error-type code and a 16-bit address field. A guarded-write violation owns the address field. A software error may place its address there only while no guarded-write violation is recorded. Reading the status word returns its current contents on `stat_word` and clears the flags and the type code at the same clock edge. The address field keeps its value. An event in the same cycle as that read is recorded after the clear.

The register map is a parameter: a 3-bit attribute per word-aligned offset. The last entry is the status word itself, which is always treated as read-only and unguarded.

Top module: `regacc_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `stat_word` is 32'h0000_0000.
- R2: A write to an offset marked guarded while `prot_en` is 1 sets bit 0 and is blocked. If bit 0 was clear before, bits 23:8 take that offset. If bit 0 was already set, bits 23:8 keep their value. With `prot_en` at 0, the same write passes and records nothing.
- R3: A software error sets bit 3. Bits 25:24 give its kind: 0 for a read of a write-only offset, 1 for a write to a read-only offset, 2 for any access to an undefined offset.
- R4: A software error writes its offset into bits 23:8 only when bit 0 is clear. Otherwise bits 23:8 are unchanged.
- R5: Once bit 3 is set, later software errors leave bits 25:24 and bits 23:8 unchanged until the status word is read.
- R6: A one-cycle pulse on `seq_fault` sets bit 2.
- R7: A read at the status offset ((NUM_REGS-1)*4, default 0x1C) returns the current word on `stat_word` in that cycle. After the edge, bits 0, 2, 3 and 25:24 are zero and bits 23:8 are unchanged.
- R8: An event in the same cycle as a status read appears in the word after the clear.
- R9: `reg_wr_en` is 1 only for a write to a read-write or write-only offset that is not a guarded-write violation.
- R10: A write to the status offset is a software error of kind 1 and is blocked.
- R11: Bits 31:26, 7:4 and 1 of `stat_word` always read 0.
- R12: The default attribute map, by word offset, is: 0x00 read-write guarded, 0x04 read-write, 0x08 read-only, 0x0C write-only, 0x10 write-only guarded, 0x14 undefined, 0x18 read-write guarded, 0x1C status (read-only). Unaligned offsets and offsets at or beyond 0x20 are undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte offset of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| prot_en | input | 1 | Write protection enable |
| seq_fault | input | 1 | Internal sequencer fault pulse |
| reg_wr_en | output | 1 | Write enable forwarded to the register file |
| stat_word | output | 32 | Current status word |

## Verification
Only one bus access can happen per cycle. The coincidence that matters is a status read in the same cycle as a `seq_fault` pulse, where the clear and the new event compete for the same register. The bench first records a guarded-write violation. It then issues the status read with the fault pulse raised. It checks that `stat_word` still shows the violation during the read cycle, and that after the edge only the sequencer flag is set, with the address field kept.

// File: rtl/regacc_pkg.sv
`timescale 1ns/1ps
// Shared types for the register access violation monitor.
// Assumes attribute entries are 3 bits: [1:0] kind, [2] guarded.
package regacc_pkg;

    typedef enum logic [1:0] {
        KIND_RW    = 2'd0,
        KIND_RO    = 2'd1,
        KIND_WO    = 2'd2,
        KIND_UNDEF = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SWT_RD_WO  = 2'd0,
        SWT_WR_RO  = 2'd1,
        SWT_UNDEF  = 2'd2,
        SWT_RSVD   = 2'd3
    } swtype_e;

    localparam int unsigned ATTR_W = 3;
    localparam int unsigned SRC_W  = 16;

endpackage

// File: rtl/regacc_attr_lookup.sv
`timescale 1ns/1ps
// Attribute lookup: maps a byte offset to its kind and guarded bit.
// Assumes word-aligned entries at 4*i. The last entry is the status word,
// which is forced to read-only and unguarded whatever the map says.
module regacc_attr_lookup
    import regacc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_REGS = 8,
    parameter logic [ATTR_W*NUM_REGS-1:0] ATTR_MAP = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output logic              guarded
);
    localparam int unsigned STAT_IDX = NUM_REGS - 1;

    logic  [NUM_REGS-1:0] hit;
    kind_e                ent_kind  [NUM_REGS];
    logic  [NUM_REGS-1:0] ent_guard;

    // Per-entry decode of the map and address match.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        assign hit[i] = (addr == ADDR_W'(4 * i));
        if (i == STAT_IDX) begin : g_stat
            assign ent_kind[i]  = KIND_RO;
            assign ent_guard[i] = 1'b0;
        end else begin : g_map
            assign ent_kind[i]  = kind_e'(ATTR_MAP[ATTR_W*i +: 2]);
            assign ent_guard[i] = ATTR_MAP[ATTR_W*i + 2];
        end
    end

    // Select the matching entry; no match means undefined.
    always_comb begin
        kind    = KIND_UNDEF;
        guarded = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) begin
                kind    = ent_kind[i];
                guarded = ent_guard[i];
            end
        end
    end

endmodule

// File: rtl/regacc_classify.sv
`timescale 1ns/1ps
// Access classifier: turns one bus access and its attribute into a
// forwarded write enable plus violation events. Assumes at most one of
// rd/wr per cycle.
module regacc_classify
    import regacc_pkg::*;
(
    input  logic    bus_rd,
    input  logic    bus_wr,
    input  kind_e   kind,
    input  logic    guarded,
    input  logic    prot_en,
    output logic    wr_en,
    output logic    ev_wp,
    output logic    ev_sw,
    output swtype_e sw_type
);
    logic writable;

    // Decide the events and whether the write may pass.
    always_comb begin
        writable = (kind == KIND_RW) || (kind == KIND_WO);
        ev_wp    = bus_wr && writable && guarded && prot_en;
        wr_en    = bus_wr && writable && !ev_wp;
        ev_sw    = 1'b0;
        sw_type  = SWT_RD_WO;
        if ((bus_rd || bus_wr) && kind == KIND_UNDEF) begin
            ev_sw   = 1'b1;
            sw_type = SWT_UNDEF;
        end else if (bus_wr && kind == KIND_RO) begin
            ev_sw   = 1'b1;
            sw_type = SWT_WR_RO;
        end else if (bus_rd && kind == KIND_WO) begin
            ev_sw   = 1'b1;
            sw_type = SWT_RD_WO;
        end
    end

endmodule

// File: rtl/regacc_status.sv
`timescale 1ns/1ps
// Status word keeper: sticky flags, error type and the shared address
// field, cleared on a status read with same-cycle events applied after.
// Assumes ev_wp and ev_sw never coincide (one access per cycle).
module regacc_status
    import regacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_clr,
    input  logic             ev_wp,
    input  logic             ev_sw,
    input  swtype_e          sw_type,
    input  logic             seq_fault,
    input  logic [SRC_W-1:0] offset,
    output logic [31:0]      stat_word
);
    logic             wp_q, seq_q, swe_q;
    swtype_e          typ_q;
    logic [SRC_W-1:0] src_q;

    logic             wp_b, seq_b, swe_b;
    swtype_e          typ_b;
    logic             wp_n, seq_n, swe_n;
    swtype_e          typ_n;
    logic [SRC_W-1:0] src_n;

    // Next state: clear on read first, then apply this cycle's events.
    always_comb begin
        wp_b  = rd_clr ? 1'b0 : wp_q;
        seq_b = rd_clr ? 1'b0 : seq_q;
        swe_b = rd_clr ? 1'b0 : swe_q;
        typ_b = rd_clr ? SWT_RD_WO : typ_q;
        wp_n  = wp_b;
        seq_n = seq_b;
        swe_n = swe_b;
        typ_n = typ_b;
        src_n = src_q;
        if (ev_wp) begin
            if (!wp_b) src_n = offset;
            wp_n = 1'b1;
        end
        if (ev_sw) begin
            if (!swe_b) begin
                typ_n = sw_type;
                if (!wp_b) src_n = offset;
            end
            swe_n = 1'b1;
        end
        if (seq_fault) seq_n = 1'b1;
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= 1'b0;
            seq_q <= 1'b0;
            swe_q <= 1'b0;
            typ_q <= SWT_RD_WO;
            src_q <= '0;
        end else begin
            wp_q  <= wp_n;
            seq_q <= seq_n;
            swe_q <= swe_n;
            typ_q <= typ_n;
            src_q <= src_n;
        end
    end

    // Pack the fields into the visible word.
    assign stat_word = {6'b0, typ_q, src_q, 4'b0, swe_q, seq_q, 1'b0, wp_q};

    a_r2_wp_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wp |=> stat_word[0]);
    a_r6_seq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |=> stat_word[2]);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_wp && !ev_sw && !seq_fault)
        |=> (stat_word[0] == 1'b0 && stat_word[3:2] == 2'b00 && stat_word[25:24] == 2'b00));
    a_r7_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !ev_wp && !ev_sw) |=> $stable(stat_word[23:8]));
    a_r4_src_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[0] && !rd_clr) |=> $stable(stat_word[23:8]));
    a_r5_type_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[3] && !rd_clr) |=> $stable(stat_word[25:24]));

endmodule

// File: rtl/regacc_guard.sv
`timescale 1ns/1ps
// Register access violation monitor top. Looks up the addressed word,
// gates writes, and keeps the clear-on-read status word.
// Assumes bus_rd and bus_wr are never high together and ADDR_W <= 16.
module regacc_guard
    import regacc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_REGS = 8,
    parameter logic [ATTR_W*NUM_REGS-1:0] ATTR_MAP = {
        3'b001, 3'b100, 3'b011, 3'b110, 3'b010, 3'b001, 3'b000, 3'b100}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              prot_en,
    input  logic              seq_fault,
    output logic              reg_wr_en,
    output logic [31:0]       stat_word
);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4 * (NUM_REGS - 1));

    kind_e   kind;
    logic    guarded;
    logic    ev_wp, ev_sw, rd_clr;
    swtype_e sw_type;

    regacc_attr_lookup #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .ATTR_MAP (ATTR_MAP)
    ) u_lookup (
        .addr    (bus_addr),
        .kind    (kind),
        .guarded (guarded)
    );

    regacc_classify u_classify (
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .kind    (kind),
        .guarded (guarded),
        .prot_en (prot_en),
        .wr_en   (reg_wr_en),
        .ev_wp   (ev_wp),
        .ev_sw   (ev_sw),
        .sw_type (sw_type)
    );

    // Status read detection: a read at the status word's own offset.
    assign rd_clr = bus_rd && (bus_addr == STAT_OFS);

    regacc_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clr    (rd_clr),
        .ev_wp     (ev_wp),
        .ev_sw     (ev_sw),
        .sw_type   (sw_type),
        .seq_fault (seq_fault),
        .offset    (SRC_W'(bus_addr)),
        .stat_word (stat_word)
    );

    a_r9_ro_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind == KIND_RO) |-> !reg_wr_en);
    a_r9_undef_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && kind == KIND_UNDEF) |-> !reg_wr_en);
    a_r10_stat_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_OFS && !stat_word[3]) |=> (stat_word[3] && stat_word[25:24] == 2'd1));
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[31:26] == 6'b0) && (stat_word[7:4] == 4'b0) && !stat_word[1]);

endmodule

// File: tb/regacc_guard_bench.sv
`timescale 1ns/1ps
// Bench: walks a vector table of accesses with expected write enable and
// status word, then directed checks for reset and the read/fault collision.
module regacc_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, prot_en = 1'b0, seq_fault = 1'b0;
    logic        reg_wr_en;
    logic [31:0] stat_word;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    regacc_guard u_regacc_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .prot_en   (prot_en),
        .seq_fault (seq_fault),
        .reg_wr_en (reg_wr_en),
        .stat_word (stat_word)
    );

    // {rd, wr, prot_en, fault, addr[15:0], exp_wr_en, exp_stat[31:0]}
    localparam int NV = 20;
    localparam logic [52:0] VEC [NV] = '{
        {4'b0110, 16'h0004, 1'b1, 32'h0000_0000},
        {4'b0100, 16'h0000, 1'b1, 32'h0000_0000},
        {4'b0110, 16'h0018, 1'b0, 32'h0000_1801},
        {4'b0110, 16'h0000, 1'b0, 32'h0000_1801},
        {4'b1010, 16'h000C, 1'b0, 32'h0000_1809},
        {4'b1010, 16'h001C, 1'b0, 32'h0000_1800},
        {4'b0110, 16'h0008, 1'b0, 32'h0100_0808},
        {4'b1010, 16'h0014, 1'b0, 32'h0100_0808},
        {4'b0110, 16'h0010, 1'b0, 32'h0100_1009},
        {4'b1010, 16'h001C, 1'b0, 32'h0000_1000},
        {4'b1010, 16'h0014, 1'b0, 32'h0200_1408},
        {4'b0011, 16'h0004, 1'b0, 32'h0200_140C},
        {4'b1010, 16'h001C, 1'b0, 32'h0000_1400},
        {4'b0110, 16'h001C, 1'b0, 32'h0100_1C08},
        {4'b1010, 16'h001C, 1'b0, 32'h0000_1C00},
        {4'b0110, 16'h000C, 1'b1, 32'h0000_1C00},
        {4'b0100, 16'h0010, 1'b1, 32'h0000_1C00},
        {4'b1010, 16'h0006, 1'b0, 32'h0200_0608},
        {4'b1010, 16'h0040, 1'b0, 32'h0200_0608},
        {4'b1010, 16'h001C, 1'b0, 32'h0000_0600}
    };

    string vreq [NV] = '{
        "R9 R12", "R2 R9", "R2 R12", "R2 R4", "R3 R4", "R7",
        "R3 R10", "R5", "R2 R4", "R7", "R3 R12", "R6", "R7",
        "R10", "R7", "R9", "R2 R9", "R3 R12", "R5 R12", "R7"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample enable, then status after the edge.
    task automatic access(input logic rd, input logic wr, input logic pe,
                          input logic flt, input logic [15:0] a,
                          output logic wen, output logic [31:0] pre,
                          output logic [31:0] post);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; prot_en = pe; seq_fault = flt; bus_addr = a;
        #1;
        wen = reg_wr_en;
        pre = stat_word;
        @(posedge clk);
        #1;
        post = stat_word;
        bus_rd = 1'b0; bus_wr = 1'b0; seq_fault = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic        wen;
        logic [31:0] pre, post;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", stat_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            access(v[52], v[51], v[50], v[49], v[48:33], wen, pre, post);
            check({vreq[i], " wr_en"}, {31'b0, wen}, {31'b0, v[32]});
            check({vreq[i], " status"}, post, v[31:0]);
            check("R11 unused bits", post & 32'hFC00_00F2, 32'h0);
        end

        // R8: guarded write, then status read colliding with a fault pulse.
        access(1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, wen, pre, post);
        check("R2 setup", post, 32'h0000_0001);
        access(1'b1, 1'b0, 1'b1, 1'b1, 16'h001C, wen, pre, post);
        check("R7 snapshot", pre, 32'h0000_0001);
        check("R8 fault kept after clear", post, 32'h0000_0004);
        access(1'b1, 1'b0, 1'b1, 1'b0, 16'h001C, wen, pre, post);
        check("R7 second read", post, 32'h0000_0000);

        // R1: reset in mid-run clears everything, including the address field.
        access(1'b0, 1'b1, 1'b0, 1'b1, 16'h0008, wen, pre, post);
        check("R3 setup", post, 32'h0100_080C);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", stat_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule